// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the device end of a five-wire serial link that software or a controller uses to reach a small bank of 8-bit control registers. The wires are an asynchronous reset, the serial clock, a command line, a serial data input and a serial data output. All inputs are sampled, and the output is launched, on the falling edge of the serial clock.

A transaction is a fixed 32-bit frame on the command line, most significant bit first. It opens with the start pattern `1100` and then carries the following fields:
- a 2-bit opcode;
- an 8-bit identifier field, made of two zero pad bits and a 6-bit device identifier;
- an 8-bit register address;
- one zero gap bit;
- eight data bits, which are write data, or zeros during a read;
- one final zero bit.

Writes store the data byte into the addressed register. Reads return the addressed register on the data output during the eight data cycles.

Each device holds its own 6-bit identifier in a register that can be reached through the link. A device write or device read acts only when the identifier field matches that register. A broadcast write or forced read acts on every device. When a device read is addressed to some other device, this block copies its data input to its data output for the eight data cycles. Devices can therefore be chained, with each data output feeding the next device's data input.

Top module: `scr_slave`

## Requirements
- R1: While idle, the block detects the command-line bit sequence 1,1,0,0 on four consecutive falling edges and treats it as bits 0..3 of a 32-bit frame. It returns to idle after frame bit 31. A new frame may start on the very next cycle.
- R2: Frame bit order after the start is: opcode bits 4..5, zero pads 6..7, identifier 8..13, address 14..21, gap 22, data 23..30, final bit 31. Every field is sent MSB first.
- R3: Opcode 00 (device write) writes the data byte to the addressed register only if bits 8..13 equal the device identifier. Otherwise nothing changes.
- R4: Opcode 01 (broadcast write) writes the data byte whatever the identifier field holds.
- R5: On opcode 10 (device read) with a matching identifier, the addressed register appears on `sdo` MSB first. Bit 7 is valid from the falling edge that samples gap bit 22 until the edge that samples bit 23. Each following bit lasts one cycle, up to the edge that samples bit 30.
- R6: Opcode 11 (forced read) drives register data as in R5 whatever the identifier field holds.
- R7: On opcode 10 with a non-matching identifier, `sdo` equals `sdi` over the same eight-cycle window.
- R8: Outside the read window, and during every write frame, `sdo` is held at 0.
- R9: A 1,1,0,0 sequence that appears inside a frame does not restart or shorten that frame.
- R10: The device identifier lives at address `SID_ADDR`, resets to 0, is written from the low 6 data bits, and reads back with the upper two bits zero.
- R11: Addresses 0..NUM_REGS-1 are 8-bit registers that reset to 0. Any other address except `SID_ADDR` reads as 0 and ignores writes.
- R12: Asserting `rst`, even in the middle of a frame, returns the block to idle, clears all registers and the identifier, and holds `sdo` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset |
| sck | input | 1 | Serial clock; falling edge samples and launches |
| cmd_in | input | 1 | Serial command line carrying the frames |
| sdi | input | 1 | Serial data input from the upstream device |
| sdo | output | 1 | Serial data output (read data or forwarded input) |

## Verification
The bench builds the block with `NUM_REGS` = 8 and `SID_ADDR` = 8. With these values the last implemented register (7), the identifier register and the first unimplemented address (9) all sit next to each other. Every boundary of the address decode can then be reached with a few frames. The defaults of 8-bit address and data keep the frame at 32 bits. Reads are compared against register values tracked from earlier writes, forwarded bytes against the pattern driven on `sdi`, and mismatched writes against values that must survive.

// File: rtl/scr_pkg.sv
package scr_pkg;

   typedef enum logic [1:0] {
      OP_DEV_WR   = 2'b00,
      OP_BCAST_WR = 2'b01,
      OP_DEV_RD   = 2'b10,
      OP_FORCE_RD = 2'b11
   } scr_op_e;

   localparam logic [3:0] FRAME_START = 4'b1100;
   localparam int         ID_FIELD_W  = 8;

endpackage

// File: rtl/scr_frame_rx.sv
module scr_frame_rx
   import scr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ID_W   = 6
) (
   input  logic              rst,
   input  logic              sck,
   input  logic              cmd_in,
   output scr_op_e           op,
   output logic [ID_W-1:0]   id_fld,
   output logic [ADDR_W-1:0] addr_fld,
   output logic [DATA_W-1:0] data_fld,
   output logic              at_gap,
   output logic              at_data_end,
   output logic              at_last,
   output logic              in_data
);

   localparam int OP_POS    = 4;
   localparam int ID_POS    = OP_POS + 2;
   localparam int ADDR_POS  = ID_POS + ID_FIELD_W;
   localparam int GAP_POS   = ADDR_POS + int'(ADDR_W);
   localparam int DATA_POS  = GAP_POS + 1;
   localparam int DEND_POS  = DATA_POS + int'(DATA_W) - 1;
   localparam int LAST_POS  = DEND_POS + 1;
   localparam int FRAME_LEN = LAST_POS + 1;
   localparam int CNT_W     = $clog2(FRAME_LEN);

   localparam logic [CNT_W-1:0] C_OP   = CNT_W'(OP_POS);
   localparam logic [CNT_W-1:0] C_ID   = CNT_W'(ID_POS);
   localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(ADDR_POS);
   localparam logic [CNT_W-1:0] C_GAP  = CNT_W'(GAP_POS);
   localparam logic [CNT_W-1:0] C_DATA = CNT_W'(DATA_POS);
   localparam logic [CNT_W-1:0] C_DEND = CNT_W'(DEND_POS);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAST_POS);

   if (ID_W > ID_FIELD_W) begin : g_bad_id
      $error("scr_frame_rx: ID_W exceeds the identifier field");
   end

   logic             active;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       hist;
   logic [3:0]       window;
   logic [1:0]       op_sr;

   assign window = {hist, cmd_in};

   always_ff @(negedge sck or posedge rst) begin
      if (rst) begin
         active   <= 1'b0;
         cnt      <= '0;
         hist     <= '0;
         op_sr    <= '0;
         id_fld   <= '0;
         addr_fld <= '0;
         data_fld <= '0;
      end else if (!active) begin
         if (window == FRAME_START) begin
            active <= 1'b1;
            cnt    <= C_OP;
            hist   <= '0;
         end else begin
            hist <= window[2:0];
         end
      end else begin
         if (cnt >= C_OP && cnt < C_ID)
            op_sr <= {op_sr[0], cmd_in};
         if (cnt >= C_ID && cnt < C_ADDR)
            id_fld <= {id_fld[ID_W-2:0], cmd_in};
         if (cnt >= C_ADDR && cnt < C_GAP)
            addr_fld <= {addr_fld[ADDR_W-2:0], cmd_in};
         if (cnt >= C_DATA && cnt <= C_DEND)
            data_fld <= {data_fld[DATA_W-2:0], cmd_in};
         if (cnt == C_LAST) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign op          = scr_op_e'(op_sr);
   assign at_gap      = active && (cnt == C_GAP);
   assign at_data_end = active && (cnt == C_DEND);
   assign at_last     = active && (cnt == C_LAST);
   assign in_data     = active && (cnt >= C_DATA) && (cnt <= C_DEND);

   // R9 / R1: once inside a frame, the counter walks forward without restart
   a_r9_no_restart: assert property (@(negedge sck) disable iff (rst)
      (active && cnt != C_LAST) |=> (active && cnt == $past(cnt) + 1'b1));

   // R1: the frame closes right after its last bit
   a_r1_frame_end: assert property (@(negedge sck) disable iff (rst)
      (active && cnt == C_LAST) |=> !active);

endmodule

// File: rtl/scr_reg_bank.sv
module scr_reg_bank #(
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       ID_W     = 6,
   parameter int unsigned       NUM_REGS = 16,
   parameter logic [ADDR_W-1:0] SID_ADDR = 8'hF0
) (
   input  logic              rst,
   input  logic              sck,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [ID_W-1:0]   sid
);

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("scr_reg_bank: NUM_REGS out of range");
   end
   if (int'(SID_ADDR) < int'(NUM_REGS)) begin : g_bad_sid
      $error("scr_reg_bank: SID_ADDR overlaps the register bank");
   end
   if (ID_W > DATA_W) begin : g_bad_idw
      $error("scr_reg_bank: identifier wider than a register");
   end

   logic [DATA_W-1:0] mem [NUM_REGS];
   logic [DATA_W-1:0] sid_view;
   logic              sid_hit;

   assign sid_hit = (addr == SID_ADDR);

   always_ff @(negedge sck or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < int'(NUM_REGS); i++) mem[i] <= '0;
         sid <= '0;
      end else if (we) begin
         for (int i = 0; i < int'(NUM_REGS); i++)
            if (addr == ADDR_W'(i)) mem[i] <= wdata;
         if (sid_hit) sid <= wdata[ID_W-1:0];
      end
   end

   if (ID_W < DATA_W) begin : g_sid_pad
      assign sid_view = {{(DATA_W-ID_W){1'b0}}, sid};
   end else begin : g_sid_full
      assign sid_view = sid;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < int'(NUM_REGS); i++)
         if (addr == ADDR_W'(i)) rdata = mem[i];
      if (sid_hit) rdata = sid_view;
   end

   // R10: identifier changes only through a write aimed at its address
   a_r10_sid_hold: assert property (@(negedge sck) disable iff (rst)
      !(we && sid_hit) |=> $stable(sid));

   // R11: addresses past the bank, other than the identifier, read zero
   a_r11_unimpl_zero: assert property (@(negedge sck) disable iff (rst)
      (int'(addr) >= int'(NUM_REGS) && !sid_hit) |-> (rdata == '0));

endmodule

// File: rtl/scr_sdo_path.sv
module scr_sdo_path #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              rst,
   input  logic              sck,
   input  logic              load,
   input  logic              drive_sel,
   input  logic [DATA_W-1:0] rdata,
   input  logic              stop,
   input  logic              sdi,
   output logic              sdo,
   output logic              drive,
   output logic              fwd
);

   logic [DATA_W-1:0] sr;

   always_ff @(negedge sck or posedge rst) begin
      if (rst) begin
         sr    <= '0;
         drive <= 1'b0;
         fwd   <= 1'b0;
      end else if (load) begin
         sr    <= rdata;
         drive <= drive_sel;
         fwd   <= !drive_sel;
      end else if (stop) begin
         sr    <= '0;
         drive <= 1'b0;
         fwd   <= 1'b0;
      end else if (drive) begin
         sr <= {sr[DATA_W-2:0], 1'b0};
      end
   end

   assign sdo = fwd ? sdi : (drive & sr[DATA_W-1]);

   // R8: nothing leaves the output while no read window is open
   a_r8_idle_low: assert property (@(negedge sck) disable iff (rst)
      !(drive || fwd) |-> !sdo);

endmodule

// File: rtl/scr_slave.sv
module scr_slave
   import scr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ID_W     = 6,
   parameter int unsigned NUM_REGS = 16,
   parameter logic [ADDR_W-1:0] SID_ADDR = 8'hF0
) (
   input  logic rst,
   input  logic sck,
   input  logic cmd_in,
   input  logic sdi,
   output logic sdo
);

   scr_op_e           op;
   logic [ID_W-1:0]   id_fld;
   logic [ID_W-1:0]   sid;
   logic [ADDR_W-1:0] addr_fld;
   logic [DATA_W-1:0] data_fld;
   logic [DATA_W-1:0] rdata;
   logic at_gap, at_data_end, at_last, in_data;
   logic id_match, is_read, all_devs, we, drive, fwd;

   scr_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_rx (
      .rst(rst), .sck(sck), .cmd_in(cmd_in),
      .op(op), .id_fld(id_fld), .addr_fld(addr_fld), .data_fld(data_fld),
      .at_gap(at_gap), .at_data_end(at_data_end), .at_last(at_last),
      .in_data(in_data)
   );

   assign id_match = (id_fld == sid);
   assign is_read  = (op == OP_DEV_RD) || (op == OP_FORCE_RD);
   assign all_devs = (op == OP_BCAST_WR) || (op == OP_FORCE_RD);
   assign we       = at_last && !is_read && (all_devs || id_match);

   scr_reg_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .NUM_REGS(NUM_REGS), .SID_ADDR(SID_ADDR)
   ) u_bank (
      .rst(rst), .sck(sck), .we(we), .addr(addr_fld),
      .wdata(data_fld), .rdata(rdata), .sid(sid)
   );

   scr_sdo_path #(.DATA_W(DATA_W)) u_out (
      .rst(rst), .sck(sck),
      .load(at_gap && is_read), .drive_sel(all_devs || id_match),
      .rdata(rdata), .stop(at_data_end), .sdi(sdi),
      .sdo(sdo), .drive(drive), .fwd(fwd)
   );

   // R5 / R7: output drive or forwarding only inside the frame's data cycles
   a_r5_window: assert property (@(negedge sck) disable iff (rst)
      (drive || fwd) |-> in_data);

   // R7: forwarding copies the upstream input
   a_r7_forward: assert property (@(negedge sck) disable iff (rst)
      fwd |-> (sdo == sdi));

endmodule

// File: tb/scr_slave_test.sv
module scr_slave_test;

   logic rst = 1'b1, sck = 1'b0, cmd_in = 1'b0, sdi = 1'b1;
   logic sdo;

   int   n_pass = 0, n_total = 0;
   int   bitpos = -1;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] acc;

   always #10 sck = ~sck;

   scr_slave #(.NUM_REGS(8), .SID_ADDR(8'h08)) uut (
      .rst(rst), .sck(sck), .cmd_in(cmd_in), .sdi(sdi), .sdo(sdo)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_total++;
      if (ok) n_pass++;
      else $display("FAIL %s: actual %0h expected %0h", req, act, expv);
   endtask

   // driver: one full frame, expected window byte queued for the monitor
   task automatic frame(input logic [1:0] op, input logic [5:0] id,
                        input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] pat, input logic [7:0] expv,
                        input string tag);
      logic [31:0] f;
      f = {4'b1100, op, 2'b00, id, a, 1'b0, (op[1] ? 8'h00 : d), 1'b0};
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      for (int k = 0; k < 32; k++) begin
         @(posedge sck);
         bitpos = k;
         cmd_in = f[31-k];
         sdi    = (k >= 23 && k <= 30) ? pat[30-k] : 1'b1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge sck);
         bitpos = -1;
         cmd_in = 1'b0;
         sdi    = 1'b1;
      end
   endtask

   // monitor: samples mid-phase, collects the window byte, compares on bit 31
   initial begin
      acc = '0;
      forever begin
         @(posedge sck);
         #5;
         if (bitpos >= 23 && bitpos <= 30) acc = {acc[6:0], sdo};
         if (bitpos == 31) begin
            check(sdo === 1'b0, "R8 sdo low after window", int'(sdo), 0);
            if (exp_q.size() > 0) begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(acc === e, t, int'(acc), int'(e));
            end else begin
               check(1'b0, "R1 unexpected frame", int'(acc), 0);
            end
         end
         if (bitpos == -1 && !rst)
            check(sdo === 1'b0, "R8 sdo low while idle", int'(sdo), 0);
      end
   end

   initial begin
      #(20 * 200000);
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   initial begin
      idle(3);
      check(sdo === 1'b0, "R12 sdo low in reset", int'(sdo), 0);
      rst = 1'b0;
      idle(3);
      frame(2'b10, 6'h00, 8'h08, 8'h00, 8'hFF, 8'h00, "R10 identifier resets to 0");
      idle(2);
      frame(2'b10, 6'h00, 8'h07, 8'h00, 8'hFF, 8'h00, "R11 last register resets to 0");
      idle(2);
      frame(2'b00, 6'h00, 8'h03, 8'hA5, 8'hFF, 8'h00, "R8 device write keeps sdo low");
      idle(1);
      frame(2'b10, 6'h00, 8'h03, 8'h00, 8'hFF, 8'hA5, "R3 R5 matched write then read");
      idle(2);
      frame(2'b00, 6'h05, 8'h03, 8'h11, 8'hFF, 8'h00, "R3 foreign write frame");
      idle(2);
      frame(2'b10, 6'h00, 8'h03, 8'h00, 8'hFF, 8'hA5, "R3 foreign write ignored");
      idle(2);
      frame(2'b01, 6'h21, 8'h07, 8'h81, 8'hFF, 8'h00, "R4 broadcast write frame");
      idle(2);
      frame(2'b10, 6'h00, 8'h07, 8'h00, 8'hFF, 8'h81, "R4 R5 broadcast stored, MSB first");
      idle(2);
      frame(2'b01, 6'h01, 8'h08, 8'hEA, 8'hFF, 8'h00, "R10 identifier write frame");
      idle(2);
      frame(2'b10, 6'h2A, 8'h08, 8'h00, 8'hFF, 8'h2A, "R10 identifier reads with zero pad");
      idle(2);
      frame(2'b10, 6'h00, 8'h03, 8'h00, 8'h5C, 8'h5C, "R7 mismatched read forwards sdi");
      idle(2);
      frame(2'b11, 6'h17, 8'h03, 8'h00, 8'h00, 8'hA5, "R6 forced read ignores identifier");
      idle(2);
      frame(2'b00, 6'h2A, 8'h09, 8'h77, 8'hFF, 8'h00, "R11 write past bank");
      idle(2);
      frame(2'b10, 6'h2A, 8'h09, 8'h00, 8'hFF, 8'h00, "R11 address past bank reads 0");
      idle(2);
      frame(2'b00, 6'h2A, 8'h06, 8'h3C, 8'hFF, 8'h00, "R2 field order write");
      frame(2'b10, 6'h2A, 8'h06, 8'h00, 8'hFF, 8'h3C, "R2 R1 back-to-back read");
      idle(2);
      frame(2'b00, 6'h2A, 8'h02, 8'hCC, 8'hFF, 8'h00, "R9 start pattern in data");
      frame(2'b10, 6'h2A, 8'h02, 8'h00, 8'hFF, 8'hCC, "R9 frame after embedded start");
      idle(2);
      // R12: abandon a write frame half way with a reset
      for (int k = 0; k < 12; k++) begin
         @(posedge sck);
         bitpos = -2;
         cmd_in = (k < 2) ? 1'b1 : 1'b0;
      end
      @(posedge sck);
      rst = 1'b1;
      bitpos = -2;
      cmd_in = 1'b0;
      @(posedge sck);
      #5;
      check(sdo === 1'b0, "R12 sdo low during reset", int'(sdo), 0);
      rst = 1'b0;
      idle(2);
      frame(2'b10, 6'h00, 8'h03, 8'h00, 8'hFF, 8'h00, "R12 reset clears register and identifier");
      idle(3);
      check(exp_q.size() == 0, "R1 all frames completed", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

endmodule